// File: doc/BRIEF.md
# Bit-select reset PWM generator

This block is a single-channel pulse-width modulator. It runs from the system clock and advances only on a slow tick enable, nominally 32 kHz. An 8-bit counter climbs by one per tick. A two-bit prescaler does not load a period. It chooses which counter bit, once set by an increment, sends the counter straight back to zero. This gives periods of 128, 64, 32 or 16 ticks, which are 250 Hz, 500 Hz, 1 kHz and 2 kHz at 32 kHz.

The bits below the selected reset bit form the counting field. The output is high while that field is below a programmed duty value. Software programs the block through a byte-wide synchronous port that holds a control register and a duty register. Each write takes effect at once: no shadow copy is kept, and nothing waits for a period boundary. A change of prescaler keeps the current counter value.

Top module: `bitSelPwm`

## Requirements
- R1: While enabled, the counter advances by exactly one on each clock cycle where `tickEn` is high, and holds its value on every other cycle.
- R2: With prescaler p (0..3), the counter returns to zero when an increment would set bit 7-p. Starting from zero, the output period is 128, 64, 32 or 16 ticks for p = 0, 1, 2, 3.
- R3: The output is high exactly when the block is enabled and the counting field is strictly less than the duty value. The counting field is the counter ANDed with 2^(7-p)-1.
- R4: A duty value of 0 gives a constant low output. A duty value at or above the full scale 2^(7-p) gives a constant high output. With p = 0 the largest duty value, 127, still gives one low tick per 128-tick period.
- R5: Writing a new prescaler leaves the counter value unchanged. Counting then continues under the new reset bit.
- R6: A duty write changes the output comparison from the cycle after the write, including in the middle of a period.
- R7: With enable at 0, the output is low and the counter is held at zero. After enable is set, counting starts from zero.
- R8: Offset 0x00 is control, with enable in bit 7 and prescaler in bits 1:0. Offset 0x01 is duty, held in bits 6:0. Reset clears both registers, so the output is low and both offsets read 0x00.
- R9: Control bits 6:2 and duty bit 7 read as zero and ignore written values. Any other offset reads as 0x00, and a write to it changes no register.
- R10: `regRdData` shows the register at the offset on `regAddr` one cycle after the address is presented. On a write cycle it returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable, nominally 32 kHz |
| regAddr | input | 8 | Register offset |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe for the offset on `regAddr` |
| regRdData | output | 8 | Registered read data for the previous cycle's offset |
| pwmOut | output | 1 | PWM output |

## Verification
Each prescaler is run from zero with a duty of 1, so that the distance between output pulses shows the reset bit that was picked. Duty values of 0, exactly full scale and 127 at prescaler 0 separate the strict-less-than compare from an off-by-one. Directed sequences move the prescaler from 0 to 3 at counter value 100 and change the duty mid-period, which tells a kept counter and an immediate compare apart from a reset or deferred update. Long random runs mix writes, including writes to unmapped offsets, with irregular ticks, and compare every cycle of output and readback with a model built from the register rules.

// File: rtl/bitSelPwmPkg.sv
package bitSelPwmPkg;
  localparam int CNT_W = 8;
  localparam int PRE_W = 2;
  localparam int DATA_W = 8;
  localparam int DUTY_W = CNT_W - 1;
  localparam int NUM_PRE = 1 << PRE_W;
  localparam int CTRL_EN_BIT = DATA_W - 1;

  typedef struct packed {
    logic              enable;
    logic [PRE_W-1:0]  prescale;
    logic [DUTY_W-1:0] duty;
  } pwmCfg_t;
endpackage

// File: rtl/bitSelPwmRegs.sv
module bitSelPwmRegs
  import bitSelPwmPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  output pwmCfg_t           cfg
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DUTY_OFS = ADDR_W'(1);

  logic              enReg;
  logic [PRE_W-1:0]  preReg;
  logic [DUTY_W-1:0] dutyReg;
  logic [DATA_W-1:0] rdNext;
  logic              ctrlHit, dutyHit;

  assign ctrlHit = (regAddr == CTRL_OFS);
  assign dutyHit = (regAddr == DUTY_OFS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      preReg <= '0;
    end else if (regWrEn && ctrlHit) begin
      enReg  <= regWrData[CTRL_EN_BIT];
      preReg <= regWrData[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dutyReg <= '0;
    else if (regWrEn && dutyHit) dutyReg <= regWrData[DUTY_W-1:0];
  end

  always_comb begin
    rdNext = '0;
    if (ctrlHit) begin
      rdNext[CTRL_EN_BIT] = enReg;
      rdNext[PRE_W-1:0]   = preReg;
    end else if (dutyHit) begin
      rdNext[DUTY_W-1:0] = dutyReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else       regRdData <= rdNext;
  end

  assign cfg.enable   = enReg;
  assign cfg.prescale = preReg;
  assign cfg.duty     = dutyReg;

  // R8: a duty write lands in the configuration on the next cycle
  assert_duty_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && dutyHit) |=> (cfg.duty == $past(regWrData[DUTY_W-1:0])));

  // R9: reserved control bits always read back as zero
  assert_ctrl_rsvd_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlHit |=> (regRdData[CTRL_EN_BIT-1:PRE_W] == '0));

  // R9: unmapped offsets read zero and leave the configuration alone
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlHit && !dutyHit) |=> ((regRdData == '0) && $stable(cfg)));

  // R10: a duty read returns the held value one cycle later
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dutyHit && !regWrEn) |=> (regRdData == {1'b0, cfg.duty}));
endmodule

// File: rtl/bitSelPwmCore.sv
module bitSelPwmCore
  import bitSelPwmPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  pwmCfg_t cfg,
  output logic    pwmOut
);
  logic [CNT_W-1:0]  cnt, cntInc;
  logic [NUM_PRE-1:0] wrapVec;
  logic [DUTY_W-1:0] maskVec [NUM_PRE];
  logic [CNT_W-1:0]  fullVec [NUM_PRE];
  logic [DUTY_W-1:0] field;
  logic [CNT_W-1:0]  fullScale, periodLast;
  logic              wrapHit;

  assign cntInc = cnt + CNT_W'(1);

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
    localparam int RST_BIT = CNT_W - 1 - p;
    assign wrapVec[p] = cntInc[RST_BIT];
    assign maskVec[p] = DUTY_W'((1 << RST_BIT) - 1);
    assign fullVec[p] = CNT_W'(1 << RST_BIT);
  end

  assign wrapHit    = wrapVec[cfg.prescale];
  assign field      = cnt[DUTY_W-1:0] & maskVec[cfg.prescale];
  assign fullScale  = fullVec[cfg.prescale];
  assign periodLast = fullScale - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (!cfg.enable) cnt <= '0;
    else if (tickEn)      cnt <= wrapHit ? '0 : cntInc;
  end

  assign pwmOut = cfg.enable && (field < cfg.duty);

  // R1: no tick, no movement
  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && !tickEn) |=> (cnt == $past(cnt)));

  // R2: last count of a period returns to zero on the next tick
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && tickEn && (cnt == periodLast)) |=> (cnt == '0));

  // R7: disabled means counter cleared and output low
  assert_off_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (cnt == '0));
  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> !pwmOut);

  // R4: duty extremes
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.duty == '0) |-> !pwmOut);
  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.enable && ({1'b0, cfg.duty} >= fullScale)) |-> pwmOut);
endmodule

// File: rtl/bitSelPwm.sv
module bitSelPwm
  import bitSelPwmPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regWrEn,
  output logic [DATA_W-1:0] regRdData,
  output logic              pwmOut
);
  pwmCfg_t cfg;

  bitSelPwmRegs #(.ADDR_W(ADDR_W)) i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdData (regRdData),
    .cfg       (cfg)
  );

  bitSelPwmCore i_core (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .cfg    (cfg),
    .pwmOut (pwmOut)
  );
endmodule

// File: tb/test_bitSelPwm.sv
`timescale 1ns/1ps
module test_bitSelPwm;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic       pwmOut;

  int nChecks = 0;
  int nFails = 0;

  bitSelPwm i_bitSelPwm (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData),
    .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  // model built from the register and counting rules
  logic [7:0] mCnt = '0, mRd = '0, mNxt;
  logic       mEn = 1'b0;
  logic [1:0] mPre = '0;
  logic [6:0] mDuty = '0;

  function automatic logic [6:0] maskOf(input logic [1:0] p);
    logic [7:0] full = 8'd1 << (7 - p);
    return 7'(full - 8'd1);
  endfunction

  function automatic logic expPwm();
    return mEn && ((mCnt[6:0] & maskOf(mPre)) < mDuty);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mEn = 1'b0; mPre = '0; mDuty = '0; mRd = '0;
    end else begin
      mRd = (regAddr == 8'd0) ? {mEn, 5'd0, mPre} :
            (regAddr == 8'd1) ? {1'b0, mDuty} : 8'd0;
      if (!mEn) mCnt = '0;
      else if (tickEn) begin
        mNxt = mCnt + 8'd1;
        mCnt = mNxt[3'(7 - mPre)] ? 8'd0 : mNxt;
      end
      if (regWrEn && regAddr == 8'd0) begin mEn = regWrData[7]; mPre = regWrData[1:0]; end
      if (regWrEn && regAddr == 8'd1) mDuty = regWrData[6:0];
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check("R3", int'(pwmOut), int'(expPwm()));
    check("R10", int'(regRdData), int'(mRd));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    cyc();
    regWrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) cyc();
    tickEn = 1'b0;
  endtask

  initial begin
    #4000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int k;
    int highs;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc();
    check("R8", int'(pwmOut), 0);
    regAddr = 8'd0; cyc(); check("R8", int'(regRdData), 0);
    regAddr = 8'd1; cyc(); check("R8", int'(regRdData), 0);

    // R9 reserved bits and unmapped offsets
    wr(8'd0, 8'hFF); regAddr = 8'd0; cyc(); check("R9", int'(regRdData), 8'h83);
    wr(8'd0, 8'h00);
    wr(8'd1, 8'hFF); regAddr = 8'd1; cyc(); check("R9", int'(regRdData), 8'h7F);
    wr(8'd2, 8'hFF); regAddr = 8'd2; cyc(); check("R9", int'(regRdData), 0);
    wr(8'hF1, 8'hFF);
    regAddr = 8'd0; cyc(); check("R9", int'(regRdData), 0);
    regAddr = 8'd1; cyc(); check("R9", int'(regRdData), 8'h7F);

    // R10 write cycle returns old value, then new
    wr(8'd1, 8'h22); check("R10", int'(regRdData), 8'h7F);
    cyc(); check("R10", int'(regRdData), 8'h22);

    // R1 counter holds without tick
    wr(8'd1, 8'd1); wr(8'd0, 8'h83);
    for (int i = 0; i < 5; i++) begin cyc(); check("R1", int'(pwmOut), 1); end
    ticks(1); check("R1", int'(pwmOut), 0);

    // R2 period per prescaler
    for (int p = 0; p < 4; p++) begin
      wr(8'd0, 8'h00); wr(8'd1, 8'd1); wr(8'd0, 8'h80 | 8'(p));
      tickEn = 1'b1; k = 0;
      do begin cyc(); k++; end while (!pwmOut && k < 300);
      tickEn = 1'b0;
      check("R2", k, 128 >> p);
    end

    // R4 duty extremes
    wr(8'd0, 8'h00); wr(8'd1, 8'd0); wr(8'd0, 8'h81);
    tickEn = 1'b1;
    for (int i = 0; i < 64; i++) begin cyc(); check("R4", int'(pwmOut), 0); end
    tickEn = 1'b0; wr(8'd1, 8'd64); tickEn = 1'b1;
    for (int i = 0; i < 64; i++) begin cyc(); check("R4", int'(pwmOut), 1); end
    tickEn = 1'b0; wr(8'd0, 8'h80); wr(8'd1, 8'd127);
    tickEn = 1'b1; highs = 0;
    for (int i = 0; i < 128; i++) begin cyc(); highs += int'(pwmOut); end
    tickEn = 1'b0;
    check("R4", highs, 127);

    // R5 prescaler change keeps the counter
    wr(8'd0, 8'h00); wr(8'd1, 8'd5); wr(8'd0, 8'h80);
    ticks(100);
    wr(8'd0, 8'h83); check("R5", int'(pwmOut), 1);
    ticks(1);  check("R5", int'(pwmOut), 0);
    ticks(11); check("R5", int'(pwmOut), 1);

    // R6 immediate duty update mid-period
    wr(8'd0, 8'h00); wr(8'd1, 8'd4); wr(8'd0, 8'h83);
    ticks(8);        check("R6", int'(pwmOut), 0);
    wr(8'd1, 8'd12); check("R6", int'(pwmOut), 1);
    wr(8'd1, 8'd8);  check("R6", int'(pwmOut), 0);

    // R7 disable clears and restarts from zero
    wr(8'd1, 8'd12);
    wr(8'd0, 8'h03); check("R7", int'(pwmOut), 0);
    ticks(5);        check("R7", int'(pwmOut), 0);
    wr(8'd1, 8'd1); wr(8'd0, 8'h83); check("R7", int'(pwmOut), 1);
    ticks(1);        check("R7", int'(pwmOut), 0);

    // R3 random mix, checked every cycle inside cyc()
    for (int i = 0; i < 4000; i++) begin
      tickEn = ($urandom % 4) != 0;
      regWrEn = ($urandom % 10) == 0;
      regAddr = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 3);
      regWrData = 8'($urandom);
      if (regAddr == 8'd0 && ($urandom % 5) != 0) regWrData[7] = 1'b1;
      cyc();
    end
    regWrEn = 1'b0; tickEn = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule